// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides, on every oscillator cycle, whether the processor's system clock is allowed to advance. At full speed the clock enable is high on every oscillator cycle. In the reduced-rate mode it gives one pulse in every 256 oscillator cycles. In the halted mode it stays low. Software changes the mode through three control bits: reduced rate, fast return, and halt. Each bit has its own write strobe.

Software may ask for the reduced rate while serial traffic is in flight or an interrupt is waiting. Such a request is dropped without any effect. When the fast-return bit is set, the block leaves the reduced rate in hardware as soon as one of several activity events appears. The events are an enabled external interrupt, a falling edge on the serial receive line, a write to the serial transmit buffer, an SPI write as master, an SPI slave select, entry to debug, and an enabled power-fail interrupt. The halted mode ends on an enabled external interrupt, a power-fail interrupt, or a wake timer interrupt. After any of these, execution continues where it stopped. It also ends on an external reset, after which the block flags that execution restarts from the reset vector.

Top module: `lpclk_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, the reduced-rate and halt bits are clear, `mode` is 0 (full speed) and `clk_en` is 1. `resume_vec` is 1 in the first cycle after rst_n is released and 0 after the next clock edge.
- R2: A write of 1 to the reduced-rate bit, when not blocked, sets `mode` to 1 one cycle later. The divider restarts at zero on entry, so `clk_en` is first high in the 256th cycle of the reduced mode. After that it is high exactly once in every 256 cycles.
- R3: A write of 0 to the reduced-rate bit sets `mode` to 0, with `clk_en` high on every cycle, from the next cycle on.
- R4: A write of 1 to the reduced-rate bit has no effect while `uart_busy`, `spi_busy` or `irq_pending` is high.
- R5: With the fast-return bit set and `mode` = 1, any one of the fast-return events clears the reduced-rate bit. In the next cycle `mode` is 0 and `clk_en` is 1.
- R6: A falling edge on `uart_rx` counts as a fast-return event only when `uart_rx_en` is 1 and `uart_mode` is not 0.
- R7: Fast-return events have no effect when the fast-return bit is 0.
- R8: A pulse on `stop_wr` sets `mode` to 2 in the next cycle. From then on `clk_en` stays 0 until the block wakes.
- R9: In mode 2, `ext_irq`, `pfail_irq` or `wut_irq` clears the halt bit in the next cycle. The reduced-rate bit keeps its value, so `mode` returns to 1 if that bit was set and to 0 if it was not.
- R10: An external reset during mode 2 ends the halt and clears the reduced-rate bit. It then behaves as in R1, with `resume_vec` high.
- R11: If a fast-return event and a write of 1 to the reduced-rate bit occur in the same cycle while `mode` = 1, the hardware clear wins and `mode` becomes 0.
- R12: In mode 2, events that only cause fast return (`debug_enter`, `uart_tx_wr`) neither wake the block nor clear the reduced-rate bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| pm_wr | input | 1 | Write strobe for the reduced-rate bit |
| pm_wdata | input | 1 | Value written to the reduced-rate bit |
| swb_wr | input | 1 | Write strobe for the fast-return bit |
| swb_wdata | input | 1 | Value written to the fast-return bit |
| stop_wr | input | 1 | Write strobe that sets the halt bit |
| uart_busy | input | 1 | Serial port transmitting or receiving |
| spi_busy | input | 1 | SPI port transmitting or receiving |
| irq_pending | input | 1 | External interrupt waiting for service |
| ext_irq | input | 1 | Enabled external interrupt fires |
| uart_rx | input | 1 | Serial receive line (idles high) |
| uart_rx_en | input | 1 | Serial reception enabled |
| uart_mode | input | 2 | Serial mode; 0 excludes receive-edge fast return |
| uart_tx_wr | input | 1 | Transmit buffer write |
| uart_tx_en | input | 1 | Serial transmission enabled |
| spi_dat_wr | input | 1 | SPI data register write |
| spi_master | input | 1 | SPI in master mode (0 = slave) |
| spi_tx_en | input | 1 | SPI transmission enabled |
| spi_ssel_n | input | 1 | SPI slave select, active low |
| debug_enter | input | 1 | Debug mode entry |
| pfail_irq | input | 1 | Enabled power-fail interrupt |
| wut_irq | input | 1 | Enabled wake timer interrupt |
| clk_en | output | 1 | System clock enable |
| mode | output | 2 | 0 full speed, 1 reduced rate, 2 halted |
| resume_vec | output | 1 | Execution restarts at the reset vector |

## Verification
Two things can fall in the same oscillator cycle: a software write that sets the reduced-rate bit, and a fast-return event that clears it in hardware. The bench provokes this in two ways. First it enters the reduced mode and drives `pm_wr`/`pm_wdata`=1 together with `debug_enter`. Then it drives the same write together with an external interrupt. In both cases the bench expects `mode` 0 and `clk_en` 1 one cycle later. The halt bit and the wake sources are also exercised together: debug and transmit-write events are applied during the halt, and the bench confirms that `mode` stays at 2 until a genuine wake source arrives.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_SLOW = 2'b01,
      MODE_HALT = 2'b10
   } lp_mode_e;

   localparam int SWB_SRC_N = 7;

endpackage

// File: rtl/lpclk_divider.sv
module lpclk_divider #(
   parameter int DIV_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam logic [DIV_W-1:0] TERM = '1;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("lpclk_divider: DIV_W must be 1..16");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run_i)
         cnt_q <= cnt_q + 1'b1;
      else
         cnt_q <= '0;
   end

   assign tick_o = run_i && (cnt_q == TERM);
endmodule

// File: rtl/lpclk_swb_detect.sv
module lpclk_swb_detect
   import lpclk_pkg::*;
#(
   parameter int UMODE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_irq,
   input  logic               uart_rx,
   input  logic               uart_rx_en,
   input  logic [UMODE_W-1:0] uart_mode,
   input  logic               uart_tx_wr,
   input  logic               uart_tx_en,
   input  logic               spi_dat_wr,
   input  logic               spi_master,
   input  logic               spi_tx_en,
   input  logic               spi_ssel_n,
   input  logic               debug_enter,
   input  logic               pfail_irq,
   output logic               evt_o
);
   generate
      if (UMODE_W < 1) begin : g_bad_umode
         $error("lpclk_swb_detect: UMODE_W must be at least 1");
      end
   endgenerate

   logic                 rx_q;
   logic [SWB_SRC_N-1:0] src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= 1'b1;
      else
         rx_q <= uart_rx;
   end

   assign src[0] = ext_irq;
   assign src[1] = rx_q && !uart_rx && uart_rx_en && (uart_mode != '0);
   assign src[2] = uart_tx_wr && uart_tx_en;
   assign src[3] = spi_dat_wr && spi_master && spi_tx_en;
   assign src[4] = !spi_master && !spi_ssel_n;
   assign src[5] = debug_enter;
   assign src[6] = pfail_irq;

   assign evt_o = |src;
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
   import lpclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int UMODE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pm_wr,
   input  logic               pm_wdata,
   input  logic               swb_wr,
   input  logic               swb_wdata,
   input  logic               stop_wr,
   input  logic               uart_busy,
   input  logic               spi_busy,
   input  logic               irq_pending,
   input  logic               ext_irq,
   input  logic               uart_rx,
   input  logic               uart_rx_en,
   input  logic [UMODE_W-1:0] uart_mode,
   input  logic               uart_tx_wr,
   input  logic               uart_tx_en,
   input  logic               spi_dat_wr,
   input  logic               spi_master,
   input  logic               spi_tx_en,
   input  logic               spi_ssel_n,
   input  logic               debug_enter,
   input  logic               pfail_irq,
   input  logic               wut_irq,
   output logic               clk_en,
   output logic [1:0]         mode,
   output logic               resume_vec
);
   logic pm_q, swb_q, stop_q, resume_q;
   logic slow_run, tick, swb_evt;
   logic set_block, swb_hit, wake_hit;
   logic pm_d, stop_d;

   assign slow_run = pm_q && !stop_q;

   lpclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (slow_run),
      .tick_o (tick)
   );

   lpclk_swb_detect #(.UMODE_W(UMODE_W)) u_swb (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_irq     (ext_irq),
      .uart_rx     (uart_rx),
      .uart_rx_en  (uart_rx_en),
      .uart_mode   (uart_mode),
      .uart_tx_wr  (uart_tx_wr),
      .uart_tx_en  (uart_tx_en),
      .spi_dat_wr  (spi_dat_wr),
      .spi_master  (spi_master),
      .spi_tx_en   (spi_tx_en),
      .spi_ssel_n  (spi_ssel_n),
      .debug_enter (debug_enter),
      .pfail_irq   (pfail_irq),
      .evt_o       (swb_evt)
   );

   assign set_block = uart_busy || spi_busy || irq_pending;
   assign swb_hit   = swb_q && slow_run && swb_evt;
   assign wake_hit  = stop_q && (ext_irq || pfail_irq || wut_irq);

   always_comb begin
      pm_d = pm_q;
      if (swb_hit)
         pm_d = 1'b0;
      else if (pm_wr)
         pm_d = pm_wdata ? (pm_q || !set_block) : 1'b0;
   end

   always_comb begin
      stop_d = stop_q;
      if (wake_hit)
         stop_d = 1'b0;
      else if (stop_wr)
         stop_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_q     <= 1'b0;
         swb_q    <= 1'b0;
         stop_q   <= 1'b0;
         resume_q <= 1'b1;
      end else begin
         pm_q     <= pm_d;
         stop_q   <= stop_d;
         resume_q <= 1'b0;
         if (swb_wr)
            swb_q <= swb_wdata;
      end
   end

   always_comb begin
      if (stop_q) begin
         clk_en = 1'b0;
         mode   = MODE_HALT;
      end else if (pm_q) begin
         clk_en = tick;
         mode   = MODE_SLOW;
      end else begin
         clk_en = 1'b1;
         mode   = MODE_RUN;
      end
   end

   assign resume_vec = resume_q;
endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pm_wr,
   input logic       pm_wdata,
   input logic       stop_wr,
   input logic       uart_busy,
   input logic       spi_busy,
   input logic       irq_pending,
   input logic       ext_irq,
   input logic       pfail_irq,
   input logic       wut_irq,
   input logic       swb_on,
   input logic       clk_en,
   input logic [1:0] mode
);
   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);

   // R2
   slow_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && clk_en && !pm_wr && !stop_wr && !ext_irq) |=> !clk_en);

   // R3
   run_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> clk_en);

   // R4
   blocked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && pm_wr && pm_wdata && !stop_wr &&
       (uart_busy || spi_busy || irq_pending)) |=> (mode == 2'b00));

   // R5
   swb_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && swb_on && ext_irq && !stop_wr) |=> (mode == 2'b00 && clk_en));

   // R8
   halt_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> !clk_en);

   // R8
   stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_wr && mode != 2'b10) |=> (mode == 2'b10));

   // R9
   wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && (ext_irq || pfail_irq || wut_irq)) |=> (mode != 2'b10));
endmodule

bind lpclk_ctrl lpclk_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pm_wr       (pm_wr),
   .pm_wdata    (pm_wdata),
   .stop_wr     (stop_wr),
   .uart_busy   (uart_busy),
   .spi_busy    (spi_busy),
   .irq_pending (irq_pending),
   .ext_irq     (ext_irq),
   .pfail_irq   (pfail_irq),
   .wut_irq     (wut_irq),
   .swb_on      (swb_q),
   .clk_en      (clk_en),
   .mode        (mode)
);

// File: tb/tb_lpclk_ctrl.sv
`timescale 1ns/1ps
module tb_lpclk_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pm_wr = 0, pm_wdata = 0, swb_wr = 0, swb_wdata = 0, stop_wr = 0;
   logic uart_busy = 0, spi_busy = 0, irq_pending = 0;
   logic ext_irq = 0, uart_rx = 1, uart_rx_en = 0;
   logic [1:0] uart_mode = 2'd0;
   logic uart_tx_wr = 0, uart_tx_en = 0, spi_dat_wr = 0, spi_master = 1;
   logic spi_tx_en = 0, spi_ssel_n = 1, debug_enter = 0, pfail_irq = 0, wut_irq = 0;
   logic clk_en, resume_vec;
   logic [1:0] mode;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lpclk_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_wdata(pm_wdata),
      .swb_wr(swb_wr), .swb_wdata(swb_wdata), .stop_wr(stop_wr),
      .uart_busy(uart_busy), .spi_busy(spi_busy), .irq_pending(irq_pending),
      .ext_irq(ext_irq), .uart_rx(uart_rx), .uart_rx_en(uart_rx_en),
      .uart_mode(uart_mode), .uart_tx_wr(uart_tx_wr), .uart_tx_en(uart_tx_en),
      .spi_dat_wr(spi_dat_wr), .spi_master(spi_master), .spi_tx_en(spi_tx_en),
      .spi_ssel_n(spi_ssel_n), .debug_enter(debug_enter), .pfail_irq(pfail_irq),
      .wut_irq(wut_irq), .clk_en(clk_en), .mode(mode), .resume_vec(resume_vec)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic write_pm(input logic v);
      @(negedge clk); pm_wr = 1; pm_wdata = v;
      @(negedge clk); pm_wr = 0; pm_wdata = 0;
   endtask

   task automatic write_swb(input logic v);
      @(negedge clk); swb_wr = 1; swb_wdata = v;
      @(negedge clk); swb_wr = 0; swb_wdata = 0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_wr = 1;
      @(negedge clk); stop_wr = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "resume_vec after release", resume_vec, 1);
      chk("R1", "mode after reset", mode, 0);
      chk("R1", "clk_en after reset", clk_en, 1);
      @(negedge clk);
      chk("R1", "resume_vec one edge later", resume_vec, 0);
   endtask

   task automatic t_slow_rate();
      int first, cnt;
      write_pm(1);
      chk("R2", "mode on entry", mode, 1);
      first = 0; cnt = 0;
      for (int k = 1; k <= 512; k++) begin
         if (clk_en) begin
            cnt++;
            if (first == 0) first = k;
         end
         @(negedge clk);
      end
      chk("R2", "first slow pulse cycle", first, 256);
      chk("R2", "pulses in 512 cycles", cnt, 2);
   endtask

   task automatic t_slow_exit();
      write_pm(0);
      chk("R3", "mode after clear", mode, 0);
      chk("R3", "clk_en after clear", clk_en, 1);
      @(negedge clk);
      chk("R3", "clk_en full rate", clk_en, 1);
   endtask

   task automatic t_blocked();
      uart_busy = 1; write_pm(1); uart_busy = 0;
      chk("R4", "uart busy blocks", mode, 0);
      spi_busy = 1; write_pm(1); spi_busy = 0;
      chk("R4", "spi busy blocks", mode, 0);
      irq_pending = 1; write_pm(1); irq_pending = 0;
      chk("R4", "irq pending blocks", mode, 0);
   endtask

   task automatic swb_event(input int which, input string name);
      write_pm(1);
      repeat (3) @(negedge clk);
      chk("R5", {name, " pre mode"}, mode, 1);
      case (which)
         0: ext_irq = 1;
         1: begin uart_rx_en = 1; uart_mode = 2'd1; uart_rx = 0; end
         2: begin uart_tx_en = 1; uart_tx_wr = 1; end
         3: begin spi_master = 1; spi_tx_en = 1; spi_dat_wr = 1; end
         4: begin spi_master = 0; spi_ssel_n = 0; end
         5: debug_enter = 1;
         default: pfail_irq = 1;
      endcase
      @(negedge clk);
      ext_irq = 0; uart_rx = 1; uart_tx_wr = 0; spi_dat_wr = 0;
      spi_master = 1; spi_ssel_n = 1; debug_enter = 0; pfail_irq = 0;
      chk("R5", {name, " mode"}, mode, 0);
      chk("R5", {name, " clk_en"}, clk_en, 1);
      uart_rx_en = 0; uart_mode = 0; uart_tx_en = 0; spi_tx_en = 0;
   endtask

   task automatic t_switchback();
      write_swb(1);
      swb_event(0, "ext irq");
      swb_event(1, "rx fall");
      swb_event(2, "tx write");
      swb_event(3, "spi write");
      swb_event(4, "slave select");
      swb_event(5, "debug");
      swb_event(6, "power fail");
   endtask

   task automatic t_rx_qual();
      write_pm(1);
      uart_rx_en = 0; uart_mode = 2'd2; uart_rx = 0;
      @(negedge clk); uart_rx = 1; @(negedge clk);
      chk("R6", "rx edge with reception off", mode, 1);
      uart_rx_en = 1; uart_mode = 2'd0; uart_rx = 0;
      @(negedge clk); uart_rx = 1; @(negedge clk);
      chk("R6", "rx edge in serial mode 0", mode, 1);
      uart_rx_en = 0;
      write_pm(0);
   endtask

   task automatic t_swb_off();
      write_swb(0);
      write_pm(1);
      debug_enter = 1; ext_irq = 1;
      @(negedge clk); debug_enter = 0; ext_irq = 0;
      @(negedge clk);
      chk("R7", "events with fast return off", mode, 1);
      write_pm(0);
      write_swb(1);
   endtask

   task automatic t_stop();
      do_stop();
      chk("R8", "mode after stop", mode, 2);
      begin
         int hi = 0;
         for (int k = 0; k < 300; k++) begin
            if (clk_en) hi++;
            @(negedge clk);
         end
         chk("R8", "clk_en highs while halted", hi, 0);
      end
   endtask

   task automatic t_halt_ignore();
      debug_enter = 1; uart_tx_en = 1; uart_tx_wr = 1;
      @(negedge clk); debug_enter = 0; uart_tx_wr = 0; uart_tx_en = 0;
      @(negedge clk);
      chk("R12", "debug/tx write during halt", mode, 2);
   endtask

   task automatic t_wake();
      // halted from full speed, external interrupt
      ext_irq = 1; @(negedge clk); ext_irq = 0;
      chk("R9", "ext irq wake to run", mode, 0);
      do_stop();
      pfail_irq = 1; @(negedge clk); pfail_irq = 0;
      chk("R9", "power-fail wake to run", mode, 0);
      // halted from reduced rate, timer wake keeps reduced bit
      write_swb(0);
      write_pm(1);
      do_stop();
      chk("R9", "stop from slow", mode, 2);
      t_halt_ignore();
      wut_irq = 1; @(negedge clk); wut_irq = 0;
      chk("R9", "timer wake back to slow", mode, 1);
      write_pm(0);
      write_swb(1);
   endtask

   task automatic t_stop_reset();
      write_pm(1);
      do_stop();
      chk("R10", "halted before reset", mode, 2);
      do_reset();
      chk("R10", "mode after reset", mode, 0);
      chk("R10", "resume_vec after reset", resume_vec, 1);
      chk("R10", "clk_en after reset", clk_en, 1);
   endtask

   task automatic t_collide();
      write_swb(1);
      write_pm(1);
      @(negedge clk);
      pm_wr = 1; pm_wdata = 1; debug_enter = 1;
      @(negedge clk);
      pm_wr = 0; pm_wdata = 0; debug_enter = 0;
      chk("R11", "fast return beats set write", mode, 0);
      write_pm(1);
      @(negedge clk);
      pm_wr = 1; pm_wdata = 1; ext_irq = 1;
      @(negedge clk);
      pm_wr = 0; pm_wdata = 0; ext_irq = 0;
      chk("R11", "irq return beats set write", mode, 0);
      chk("R11", "clk_en after collision", clk_en, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_slow_rate();
      t_slow_exit();
      t_blocked();
      t_switchback();
      t_rx_qual();
      t_swb_off();
      t_stop();
      t_wake();
      t_stop_reset();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule